// File: doc/BRIEF.md
# Memory-mapped register write lock

This block guards a small bank of memory-mapped scratch registers against stray writes. A 32-bit lock-access register is placed at a fixed offset in the register window. A bus write of one exact 32-bit key to that register opens the lock. A write of any other value closes it. While the lock is closed, bus writes to the protected registers complete normally but leave the contents unchanged. Reads of the protected registers work in both states.

A lock-status register gives software a way to check the lock. Its bit 0 says whether the lock feature is built in, and its bit 1 says whether the lock is currently closed. A power-good input stands in for the core power domain. When the power option is enabled and the core is unpowered, any access to the lock-access register ends with an error response and leaves the lock as it was.

The bus is a simple single-beat port. Each cycle with a write or read strobe is one access. One cycle later the block returns a ready pulse, together with the read data and an error flag.

Top module: `mmio_wr_lock`

## Requirements
- R1: After reset the lock is closed, and a read of the status register at offset 0xFB4 returns 0x3 when the lock feature is built in.
- R2: A powered write of exactly 0xC5ACCE55 to offset 0xFB0 opens the lock, and the status register then reads 0x1.
- R3: A powered write of any other 32-bit value to offset 0xFB0 closes the lock, whatever state it was in.
- R4: While the lock is closed, a write to a protected register gets ready with no error, and a later read returns the old contents.
- R5: While the lock is open, a write to a protected register updates it. Reads of protected registers return their contents in both lock states.
- R6: In the status register, bit 0 is 1 when the lock is built in and bit 1 is 1 when the lock is closed. Bits 31 to 2 read 0.
- R7: The lock-access register is write-only. A read of offset 0xFB0 returns 0 with no error.
- R8: When the power option is enabled and core_pwr_ok is 0, a read or write of offset 0xFB0 returns ready with bus_err=1 and rdata 0, and the lock state does not change.
- R9: Every cycle with bus_we or bus_re set produces bus_ready=1 in the next cycle, and only then. If both strobes are set, the access is a write and rdata is 0.
- R10: When the lock feature is not built in, the status register reads 0, writes to offset 0xFB0 have no effect, and protected writes are never blocked.
- R11: Protected register i sits at byte offset 4*i. A read of an unmapped offset returns 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_pwr_ok | input | 1 | Core power domain is up |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Response for the access of the previous cycle |
| bus_err | output | 1 | Error response, valid with bus_ready |

## Verification
The bench tries keys that differ from the magic value in only the lowest bit. A design that compared only part of the word would open the lock on such a key. It writes a protected register while the lock is closed and reads it back, which catches a gate that drops the write only at the response. The bench also catches a gate that blocks reads instead of writes. It removes core power and then writes the correct key; a design that let the update through, or left out the error, is caught when the status register is read again after power returns. A second instance built without the lock checks that the status reads zero and that protected writes always land.

// File: rtl/mwl_pkg.sv
package mwl_pkg;

    localparam logic [31:0] MWL_KEY = 32'hC5AC_CE55;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LAR  = 2'd1,
        TGT_LSR  = 2'd2,
        TGT_REG  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic        ready;
        logic        err;
        logic [31:0] rdata;
    } resp_t;

    typedef struct packed {
        logic locked;
    } lock_st_t;

endpackage

// File: rtl/mwl_decode.sv
module mwl_decode #(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_REGS   = 4,
    parameter logic [11:0] LAR_OFFSET = 12'hFB0,
    parameter logic [11:0] LSR_OFFSET = 12'hFB4,
    localparam int         IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output mwl_pkg::tgt_e     tgt,
    output logic [IDX_W-1:0]  idx
);
    import mwl_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] REG_LIMIT = WORD_W'(NUM_REGS);

    logic [WORD_W-1:0] word;

    always_comb begin
        word = addr[ADDR_W-1:2];
        idx  = IDX_W'(word);
        if (addr == ADDR_W'(LAR_OFFSET)) begin
            tgt = TGT_LAR;
        end else if (addr == ADDR_W'(LSR_OFFSET)) begin
            tgt = TGT_LSR;
        end else if (addr[1:0] == 2'b00 && word < REG_LIMIT) begin
            tgt = TGT_REG;
        end else begin
            tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/mwl_lock_ctrl.sv
module mwl_lock_ctrl #(
    parameter bit          LOCK_IMPL = 1'b1,
    parameter logic [31:0] KEY       = mwl_pkg::MWL_KEY
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lar_wr,
    input  logic [31:0] wdata,
    output logic        locked
);
    import mwl_pkg::*;

    generate
        if (LOCK_IMPL) begin : g_lock
            lock_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (lar_wr) begin
                    st_d.locked = (wdata != KEY);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q.locked <= 1'b1;
                end else begin
                    st_q <= st_d;
                end
            end

            assign locked = st_q.locked;
        end else begin : g_nolock
            logic unused_in;
            assign unused_in = lar_wr ^ (^wdata) ^ clk ^ rst_n;
            assign locked    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mwl_scratch_bank.sv
module mwl_scratch_bank #(
    parameter int  NUM_REGS = 4,
    parameter int  DATA_W   = 32,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_comb begin
                regs_d[i] = regs_q[i];
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    regs_d[i] = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[i] <= '0;
                end else begin
                    regs_q[i] <= regs_d[i];
                end
            end
        end
    endgenerate

    assign regs = regs_q;

endmodule

// File: rtl/mmio_wr_lock.sv
module mmio_wr_lock #(
    parameter int          ADDR_W       = 12,
    parameter int          NUM_REGS     = 4,
    parameter bit          LOCK_IMPL    = 1'b1,
    parameter bit          PWR_DOMAIN   = 1'b1,
    parameter logic [31:0] KEY          = mwl_pkg::MWL_KEY,
    parameter logic [11:0] LAR_OFFSET   = 12'hFB0,
    parameter logic [11:0] LSR_OFFSET   = 12'hFB4,
    localparam int         DATA_W       = 32,
    localparam int         IDX_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_pwr_ok,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              bus_err
);
    import mwl_pkg::*;

    tgt_e                            tgt;
    logic [IDX_W-1:0]                idx;
    logic                            locked;
    logic                            pwr_fault;
    logic                            lar_wr;
    logic                            reg_wr;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    resp_t                           resp_d, resp_q;

    mwl_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_REGS   (NUM_REGS),
        .LAR_OFFSET (LAR_OFFSET),
        .LSR_OFFSET (LSR_OFFSET)
    ) u_decode (
        .addr (bus_addr),
        .tgt  (tgt),
        .idx  (idx)
    );

    mwl_lock_ctrl #(
        .LOCK_IMPL (LOCK_IMPL),
        .KEY       (KEY)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lar_wr (lar_wr),
        .wdata  (bus_wdata),
        .locked (locked)
    );

    mwl_scratch_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_idx (idx),
        .wdata  (bus_wdata),
        .regs   (regs)
    );

    always_comb begin
        pwr_fault = PWR_DOMAIN && !core_pwr_ok;
        lar_wr    = bus_we && (tgt == TGT_LAR) && !pwr_fault;
        reg_wr    = bus_we && (tgt == TGT_REG) && !locked;

        resp_d       = '0;
        resp_d.ready = bus_we || bus_re;
        resp_d.err   = (bus_we || bus_re) && (tgt == TGT_LAR) && pwr_fault;
        if (bus_re && !bus_we && !resp_d.err) begin
            case (tgt)
                TGT_LSR: resp_d.rdata = {30'd0, locked, LOCK_IMPL};
                TGT_REG: resp_d.rdata = regs[idx];
                default: resp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign bus_ready = resp_q.ready;
    assign bus_err   = resp_q.err;
    assign bus_rdata = resp_q.rdata;

endmodule

// File: rtl/mwl_checker.sv
module mwl_checker #(
    parameter int          ADDR_W     = 12,
    parameter bit          LOCK_IMPL  = 1'b1,
    parameter bit          PWR_DOMAIN = 1'b1,
    parameter logic [31:0] KEY        = mwl_pkg::MWL_KEY,
    parameter logic [11:0] LAR_OFFSET = 12'hFB0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_pwr_ok,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              bus_ready,
    input logic              bus_err,
    input logic              locked
);
    logic at_lar;
    logic powered;
    assign at_lar  = (bus_addr == ADDR_W'(LAR_OFFSET));
    assign powered = !PWR_DOMAIN || core_pwr_ok;

    // R9
    acc_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |=> bus_ready);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !bus_re) |=> !bus_ready);

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCK_IMPL && bus_we && at_lar && powered && bus_wdata == KEY) |=> !locked);

    // R3
    other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LOCK_IMPL && bus_we && at_lar && powered && bus_wdata != KEY) |=> locked);

    // R8
    unpowered_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_we || bus_re) && at_lar && !powered) |=> (bus_err && bus_rdata == 32'd0 && $stable(locked)));

    // R7
    lar_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_we && at_lar && powered) |=> (bus_rdata == 32'd0 && !bus_err));

    // R10
    nolock_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !LOCK_IMPL |-> !locked);

    // R9
    err_has_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ready);

endmodule

bind mmio_wr_lock mwl_checker #(
    .ADDR_W     (ADDR_W),
    .LOCK_IMPL  (LOCK_IMPL),
    .PWR_DOMAIN (PWR_DOMAIN),
    .KEY        (KEY),
    .LAR_OFFSET (LAR_OFFSET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_pwr_ok (core_pwr_ok),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .bus_ready   (bus_ready),
    .bus_err     (bus_err),
    .locked      (locked)
);

// File: tb/mmio_wr_lock_tb.sv
module mmio_wr_lock_tb;

    localparam logic [11:0] A_LAR = 12'hFB0;
    localparam logic [11:0] A_LSR = 12'hFB4;
    localparam logic [31:0] GOOD  = 32'hC5AC_CE55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr = 1'b1;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we0 = 1'b0, re0 = 1'b0, we1 = 1'b0, re1 = 1'b0;
    logic [31:0] rd0, rd1;
    logic        rdy0, rdy1, err0, err1;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] r_data;
    logic        r_rdy, r_err;

    always #5 clk = ~clk;

    mmio_wr_lock u_dut (
        .clk(clk), .rst_n(rst_n), .core_pwr_ok(pwr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we0), .bus_re(re0),
        .bus_rdata(rd0), .bus_ready(rdy0), .bus_err(err0)
    );

    mmio_wr_lock #(.LOCK_IMPL(1'b0)) u_dut_nolock (
        .clk(clk), .rst_n(rst_n), .core_pwr_ok(pwr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_we(we1), .bus_re(re1),
        .bus_rdata(rd1), .bus_ready(rdy1), .bus_err(err1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input bit sel, input bit w, input bit r,
                          input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        if (sel) begin we1 = w; re1 = r; end
        else     begin we0 = w; re0 = r; end
        @(negedge clk);
        we0 = 1'b0; re0 = 1'b0; we1 = 1'b0; re1 = 1'b0;
        r_rdy  = sel ? rdy1 : rdy0;
        r_err  = sel ? err1 : err0;
        r_data = sel ? rd1  : rd0;
    endtask

    task automatic t_reset();
        access(0, 0, 1, A_LSR, 0);
        check("R1 reset status", r_data, 32'h3);
        check("R6 status ready", {31'd0, r_rdy}, 1);
        access(0, 1, 0, 12'h000, 32'h1234_5678);
        check("R4 locked write no err", {30'd0, r_rdy, r_err}, 32'h2);
        access(0, 0, 1, 12'h000, 0);
        check("R4 locked write dropped", r_data, 32'h0);
    endtask

    task automatic t_unlock();
        access(0, 1, 0, A_LAR, GOOD);
        check("R2 key write ok", {31'd0, r_err}, 0);
        access(0, 0, 1, A_LSR, 0);
        check("R2 status open", r_data, 32'h1);
        access(0, 1, 0, 12'h004, 32'hA5A5_0001);
        access(0, 0, 1, 12'h004, 0);
        check("R5 open write lands", r_data, 32'hA5A5_0001);
        access(0, 1, 0, 12'h00C, 32'h0BAD_F00D);
        access(0, 0, 1, 12'h00C, 0);
        check("R11 last reg offset", r_data, 32'h0BAD_F00D);
        access(0, 0, 1, 12'h000, 0);
        check("R11 reg0 untouched", r_data, 32'h0);
    endtask

    task automatic t_relock();
        access(0, 1, 0, A_LAR, GOOD ^ 32'h1);
        access(0, 0, 1, A_LSR, 0);
        check("R3 near key closes", r_data, 32'h3);
        access(0, 1, 0, 12'h004, 32'hDEAD_BEEF);
        check("R4 locked write ready", {31'd0, r_rdy}, 1);
        access(0, 0, 1, 12'h004, 0);
        check("R5 read while locked", r_data, 32'hA5A5_0001);
        access(0, 1, 0, A_LAR, 32'h0);
        access(0, 0, 1, A_LSR, 0);
        check("R3 zero keeps closed", r_data, 32'h3);
    endtask

    task automatic t_lar_read();
        access(0, 0, 1, A_LAR, 0);
        check("R7 lar reads zero", r_data, 32'h0);
        check("R7 lar read no err", {31'd0, r_err}, 0);
    endtask

    task automatic t_power();
        pwr = 1'b0;
        access(0, 1, 0, A_LAR, GOOD);
        check("R8 unpowered write err", {30'd0, r_rdy, r_err}, 32'h3);
        access(0, 0, 1, A_LAR, 0);
        check("R8 unpowered read err", {31'd0, r_err}, 1);
        pwr = 1'b1;
        access(0, 0, 1, A_LSR, 0);
        check("R8 lock unchanged", r_data, 32'h3);
    endtask

    task automatic t_both();
        access(0, 1, 0, A_LAR, GOOD);
        access(0, 1, 1, 12'h008, 32'h7777_8888);
        check("R9 both strobes rdata", r_data, 32'h0);
        access(0, 0, 1, 12'h008, 0);
        check("R9 both strobes wrote", r_data, 32'h7777_8888);
        @(negedge clk);
        check("R9 idle no ready", {31'd0, rdy0}, 0);
    endtask

    task automatic t_unmapped();
        access(0, 0, 1, 12'h100, 0);
        check("R11 unmapped zero", {r_data[30:0], r_err}, 32'h0);
        check("R11 unmapped ready", {31'd0, r_rdy}, 1);
    endtask

    task automatic t_nolock();
        access(1, 0, 1, A_LSR, 0);
        check("R10 status zero", r_data, 32'h0);
        access(1, 1, 0, 12'h000, 32'h1111_2222);
        access(1, 0, 1, 12'h000, 0);
        check("R10 write never blocked", r_data, 32'h1111_2222);
        access(1, 1, 0, A_LAR, 32'h0);
        access(1, 1, 0, 12'h000, 32'h3333_4444);
        access(1, 0, 1, 12'h000, 0);
        check("R10 lar write no effect", r_data, 32'h3333_4444);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock();
        t_relock();
        t_lar_read();
        t_power();
        t_both();
        t_unmapped();
        t_nolock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule